// File: doc/BRIEF.md
# Explicit-Type Operand Fetch Unit

This unit turns one source operand field, taken from the instruction register, into the operand value that an execution stage consumes. The field is self-describing. A 3-bit kind code sits in the top bits and tells the unit how to read the rest. Below it are a register number and a 16-bit value/offset subfield. Depending on the kind, the unit either extends the constant, or reads one register-file port, or adds an offset to a register, or runs one or two dependent reads on a single memory read port.

A caller pulses `start` with the field while the unit is idle. The memory port uses a request/valid handshake. The unit raises `mem_req` with `mem_addr` and waits until `mem_valid` returns the word in `mem_rdata`. For the chained kinds, the word from the first read becomes the address of the second. When the value is ready the unit raises `done` for a single cycle and presents `operand`. An illegal kind code is reported on `bad_type` together with `done`.

Top module: `operand_fetch`

## Requirements
- R1: Field layout is bits [22:20] kind, [19:16] register number, [15:0] value. Kind 000 returns the value sign-extended to 32 bits. It makes no memory request, and `done` is high in the second cycle after the cycle in which `start` was sampled.
- R2: Kind 001 returns the value zero-extended to 32 bits with no memory request. Its latency is the same as R1.
- R3: Kind 010 returns the contents of the named register with no memory request. `rf_rd` is high for exactly one cycle with `rf_addr` equal to the register number.
- R4: Kind 011 returns the named register plus the sign-extended value, modulo 2^32, with no memory request.
- R5: Kind 100 performs exactly one memory read, at the address held in the named register, and returns the word read.
- R6: Kind 101 performs exactly one memory read, at the zero-extended value, and returns the word read.
- R7: Kind 110 reads memory at the zero-extended value and gets a word A. It then reads memory at A and returns that second word. The second request is issued only after the first read has completed.
- R8: Kind 111 raises `bad_type` together with `done`, returns zero, and makes no memory request. `bad_type` is low for every other kind.
- R9: While `mem_req` is high and `mem_valid` is low, `mem_req` stays high in the next cycle and `mem_addr` stays unchanged. At most one request is outstanding at any time.
- R10: A `start` pulse that arrives while an operation is in progress is ignored. The running operation's result and read addresses are unchanged.
- R11: After reset, `done`, `mem_req` and `rf_rd` are low. `done` is high for exactly one cycle per operation, and the unit is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin fetching the operand in `op_field` |
| op_field | input | 23 | Kind, register number, value/offset |
| rf_rd | output | 1 | Register-file read strobe |
| rf_addr | output | 4 | Register-file read index |
| rf_data | input | 32 | Register-file read data, same cycle |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| done | output | 1 | One-cycle operand-ready pulse |
| operand | output | 32 | Fetched operand value |
| bad_type | output | 1 | Illegal kind code, valid with `done` |

## Verification
The sweep covers all eight kind codes, with constants at 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF. A design that swapped the two extensions, or that sign-extended a memory-direct address, would return or request the wrong upper half. A register of all ones plus an offset of one must wrap to zero, so a carry that leaked or a zero-extended offset would show up there. The memory model answers after zero to three wait cycles and records every address. Double-indirect checks that the second address is the first word read, and that exactly two reads happen. A unit that dropped its request, moved its address during a wait, or accepted a second `start` while busy would read the wrong location or return another field's value.

// File: rtl/opf_pkg.sv
package opf_pkg;
   localparam int OPK_W = 3;

   typedef enum logic [OPK_W-1:0] {
      OPK_SIMM = 3'b000,
      OPK_UIMM = 3'b001,
      OPK_REG  = 3'b010,
      OPK_ROFF = 3'b011,
      OPK_RIND = 3'b100,
      OPK_MDIR = 3'b101,
      OPK_MIND = 3'b110,
      OPK_BAD  = 3'b111
   } opk_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_EVAL = 3'd1,
      ST_RD1  = 3'd2,
      ST_RD2  = 3'd3,
      ST_FIN  = 3'd4
   } fst_e;
endpackage

// File: rtl/opf_decode.sv
module opf_decode
   import opf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_AW = 4,
   parameter int VAL_W  = 16,
   localparam int FW    = OPK_W + REG_AW + VAL_W
)(
   input  logic [FW-1:0]     field,
   output opk_e              kind,
   output logic [REG_AW-1:0] ridx,
   output logic [DATA_W-1:0] imm_val,
   output logic [DATA_W-1:0] addr_val,
   output logic [DATA_W-1:0] off_val,
   output logic              uses_reg
);
   logic [VAL_W-1:0]  raw;
   logic [DATA_W-1:0] sext, zext;

   assign kind = opk_e'(field[FW-1 -: OPK_W]);
   assign ridx = field[VAL_W +: REG_AW];
   assign raw  = field[VAL_W-1:0];

   generate
      if (VAL_W > DATA_W) begin : g_bad_w
         $error("value field wider than data path");
      end else if (VAL_W == DATA_W) begin : g_same_w
         assign sext = raw;
         assign zext = raw;
      end else begin : g_ext_w
         assign sext = {{(DATA_W-VAL_W){raw[VAL_W-1]}}, raw};
         assign zext = {{(DATA_W-VAL_W){1'b0}}, raw};
      end
   endgenerate

   assign imm_val  = (kind == OPK_UIMM) ? zext : sext;
   assign addr_val = zext;
   assign off_val  = sext;
   assign uses_reg = (kind == OPK_REG) || (kind == OPK_ROFF) || (kind == OPK_RIND);
endmodule

// File: rtl/opf_sum.sv
module opf_sum #(
   parameter int DATA_W = 32
)(
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] off,
   output logic [DATA_W-1:0] sum
);
   assign sum = base + off;
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
   import opf_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  opk_e              kind,
   input  logic              uses_reg,
   input  logic [DATA_W-1:0] imm_val,
   input  logic [DATA_W-1:0] addr_val,
   input  logic [DATA_W-1:0] sum_val,
   input  logic [DATA_W-1:0] rf_data,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              idle,
   output logic              rf_rd,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_addr,
   output logic              done,
   output logic [DATA_W-1:0] operand,
   output logic              bad_type
);
   fst_e              st_q;
   logic              chain_q;
   logic [DATA_W-1:0] addr_q, res_q;
   logic              bad_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         chain_q <= 1'b0;
         addr_q  <= '0;
         res_q   <= '0;
         bad_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) st_q <= ST_EVAL;
            ST_EVAL: begin
               bad_q   <= 1'b0;
               chain_q <= 1'b0;
               unique case (kind)
                  OPK_SIMM, OPK_UIMM: begin res_q <= imm_val; st_q <= ST_FIN; end
                  OPK_REG:  begin res_q <= rf_data; st_q <= ST_FIN; end
                  OPK_ROFF: begin res_q <= sum_val; st_q <= ST_FIN; end
                  OPK_RIND: begin addr_q <= rf_data;  st_q <= ST_RD1; end
                  OPK_MDIR: begin addr_q <= addr_val; st_q <= ST_RD1; end
                  OPK_MIND: begin addr_q <= addr_val; chain_q <= 1'b1; st_q <= ST_RD1; end
                  default:  begin res_q <= '0; bad_q <= 1'b1; st_q <= ST_FIN; end
               endcase
            end
            ST_RD1: if (mem_valid) begin
               if (chain_q) begin
                  addr_q <= mem_rdata;
                  st_q   <= ST_RD2;
               end else begin
                  res_q <= mem_rdata;
                  st_q  <= ST_FIN;
               end
            end
            ST_RD2: if (mem_valid) begin
               res_q <= mem_rdata;
               st_q  <= ST_FIN;
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign idle     = (st_q == ST_IDLE);
   assign rf_rd    = (st_q == ST_EVAL) && uses_reg;
   assign mem_req  = (st_q == ST_RD1) || (st_q == ST_RD2);
   assign mem_addr = addr_q;
   assign done     = (st_q == ST_FIN);
   assign operand  = res_q;
   assign bad_type = done && bad_q;

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && idle));
   // R8
   bad_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_type |-> (done && !mem_req && operand == '0));
   // R7
   second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RD2) |-> ($past(st_q) == ST_RD1 || $past(st_q) == ST_RD2));
   // R10
   eval_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EVAL) |-> ($past(st_q) == ST_IDLE));
endmodule

// File: rtl/operand_fetch.sv
module operand_fetch
   import opf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_N  = 16,
   parameter int VAL_W  = 16
)(
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  start,
   input  logic [OPK_W+$clog2(REG_N)+VAL_W-1:0]  op_field,
   output logic                                  rf_rd,
   output logic [$clog2(REG_N)-1:0]              rf_addr,
   input  logic [DATA_W-1:0]                     rf_data,
   output logic                                  mem_req,
   output logic [DATA_W-1:0]                     mem_addr,
   input  logic                                  mem_valid,
   input  logic [DATA_W-1:0]                     mem_rdata,
   output logic                                  done,
   output logic [DATA_W-1:0]                     operand,
   output logic                                  bad_type
);
   localparam int REG_AW = $clog2(REG_N);
   localparam int FW     = OPK_W + REG_AW + VAL_W;

   generate
      if (REG_N < 2) begin : g_chk_regs
         $error("register file needs at least two entries");
      end
      if (DATA_W < 8) begin : g_chk_data
         $error("data path too narrow");
      end
   endgenerate

   logic [FW-1:0]     field_q;
   logic              idle;
   opk_e              kind;
   logic              uses_reg;
   logic [DATA_W-1:0] imm_val, addr_val, off_val, sum_val;

   always_ff @(posedge clk) begin
      if (!rst_n)            field_q <= '0;
      else if (start && idle) field_q <= op_field;
   end

   opf_decode #(.DATA_W(DATA_W), .REG_AW(REG_AW), .VAL_W(VAL_W)) u_dec (
      .field(field_q), .kind(kind), .ridx(rf_addr), .imm_val(imm_val),
      .addr_val(addr_val), .off_val(off_val), .uses_reg(uses_reg)
   );

   opf_sum #(.DATA_W(DATA_W)) u_sum (
      .base(rf_data), .off(off_val), .sum(sum_val)
   );

   opf_ctrl #(.DATA_W(DATA_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .uses_reg(uses_reg),
      .imm_val(imm_val), .addr_val(addr_val), .sum_val(sum_val), .rf_data(rf_data),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata), .idle(idle), .rf_rd(rf_rd),
      .mem_req(mem_req), .mem_addr(mem_addr), .done(done), .operand(operand),
      .bad_type(bad_type)
   );

   // R3
   rf_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_rd |=> !rf_rd);
endmodule

// File: tb/operand_fetch_test.sv
module operand_fetch_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [22:0] op_field = '0;
   logic        rf_rd;
   logic [3:0]  rf_addr;
   logic [31:0] rf_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done;
   logic [31:0] operand;
   logic        bad_type;

   int checks = 0, errors = 0;
   int lat = 0, wait_cnt = 0, nreads = 0, hold_err = 0, rf_cnt = 0;
   logic [31:0] held, addr0, addr1;
   logic [3:0]  rf_seen;
   bit poke = 0;

   always #10 clk = ~clk;

   operand_fetch uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_field(op_field),
      .rf_rd(rf_rd), .rf_addr(rf_addr), .rf_data(rf_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .done(done), .operand(operand), .bad_type(bad_type)
   );

   function automatic logic [31:0] regv(input logic [3:0] i);
      return 32'h1111_1111 * {28'd0, i};
   endfunction

   function automatic logic [31:0] mval(input logic [31:0] a);
      return (a * 32'h0001_0003) ^ 32'h1357_9BDF;
   endfunction

   assign rf_data = regv(rf_addr);

   always @(negedge clk) begin
      if (rf_rd) begin rf_cnt++; rf_seen = rf_addr; end
      if (mem_valid) begin
         mem_valid = 1'b0;
         wait_cnt  = 0;
      end else if (mem_req) begin
         if (wait_cnt == 0) held = mem_addr;
         else if (mem_addr != held) hold_err++;
         if (wait_cnt == lat) begin
            mem_valid = 1'b1;
            mem_rdata = mval(mem_addr);
            if (nreads == 0) addr0 = mem_addr;
            else             addr1 = mem_addr;
            nreads++;
         end else wait_cnt++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [2:0] t, input logic [3:0] r, input logic [15:0] v, input int l);
      logic [31:0] sx, zx, ex, a0, a1;
      int en, ecyc, cyc;
      string tag;
      sx = {{16{v[15]}}, v};
      zx = {16'd0, v};
      a0 = 0; a1 = 0; en = 0;
      case (t)
         3'd0: begin ex = sx; tag = "R1"; end
         3'd1: begin ex = zx; tag = "R2"; end
         3'd2: begin ex = regv(r); tag = "R3"; end
         3'd3: begin ex = regv(r) + sx; tag = "R4"; end
         3'd4: begin a0 = regv(r); ex = mval(a0); en = 1; tag = "R5"; end
         3'd5: begin a0 = zx; ex = mval(a0); en = 1; tag = "R6"; end
         3'd6: begin a0 = zx; a1 = mval(a0); ex = mval(a1); en = 2; tag = "R7"; end
         default: begin ex = 0; tag = "R8"; end
      endcase
      ecyc = (en == 0) ? 2 : (en == 1) ? 3 + l : 5 + 2 * l;
      lat = l; nreads = 0; rf_cnt = 0; hold_err = 0; rf_seen = 4'hX;
      @(negedge clk);
      start = 1'b1;
      op_field = {t, r, v};
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 60) begin
         if (poke && cyc == 3) begin start = 1'b1; op_field = {3'b111, 4'd0, 16'h0}; end
         else start = 1'b0;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      if (poke) tag = "R10";
      chk({tag, " done latency"}, cyc, ecyc);
      chk({tag, " operand"}, operand, ex);
      chk({tag, "/R8 bad_type"}, {31'd0, bad_type}, {31'd0, t == 3'd7});
      chk({tag, " read count"}, nreads, en);
      if (en >= 1) chk({tag, " first address"}, addr0, a0);
      if (en == 2) chk("R7 second address", addr1, a1);
      chk("R9 address held", hold_err, 0);
      chk("R3 rf reads", rf_cnt, (t == 3'd2 || t == 3'd3 || t == 3'd4) ? 1 : 0);
      if (rf_cnt == 1) chk("R3 rf index", {28'd0, rf_seen}, {28'd0, r});
      @(negedge clk);
      chk("R11 done one cycle", {31'd0, done}, 32'd0);
      chk("R11 idle no request", {31'd0, mem_req}, 32'd0);
   endtask

   initial begin
      logic [15:0] vals [6];
      vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
      repeat (3) @(negedge clk);
      chk("R11 reset done", {31'd0, done}, 32'd0);
      chk("R11 reset mem_req", {31'd0, mem_req}, 32'd0);
      chk("R11 reset rf_rd", {31'd0, rf_rd}, 32'd0);
      rst_n = 1'b1;
      for (int t = 0; t < 8; t++)
         for (int i = 0; i < 6; i++)
            run_op(t[2:0], 4'((i * 3 + t) % 16), vals[i], (i + t) % 4);
      run_op(3'd3, 4'd15, 16'h0001, 0);    // R4 wrap to zero
      run_op(3'd3, 4'd0,  16'hFFFF, 0);    // R4 negative offset
      poke = 1;
      run_op(3'd5, 4'd0, 16'h0042, 3);     // R10 start while busy
      run_op(3'd6, 4'd0, 16'h0021, 2);     // R10 start during chain
      poke = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule